// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block holds the byte-wide task-file register set of one ATA channel that serves two drive slots. A host reaches it over a simple single-cycle register bus. It keeps the error, status, device-control and drive/head registers, and a shadow copy of the addressing registers for each slot. It decodes a small set of commands into fixed status and error codes, and it raises an interrupt request that the device-control register can mask.

Software-driven soft reset goes through the device-control register. Writing the reset bit from 0 to 1 puts the channel into its busy reset state. Writing it from 1 to 0 completes the reset and reloads the per-slot shadows, and the cylinder value depends on whether the slot holds a disk or a packet device. Selecting an empty slot is flagged in the error and status registers. While an empty slot is selected, reads see a fixed pattern. The sector data path, packet parsing and identify data are not part of this block. It only produces the status transitions that go with those commands.

Register addresses used throughout: 0 error (read) / features (write), 1 sector count, 2 sector number, 3 cylinder low, 4 cylinder high, 5 drive/head (bit 4 selects slot 1, bits 3:0 are the head), 6 status (read) / command (write), 7 alternate status (read) / device control (write; bit 2 soft reset, bit 1 interrupt disable), 8 alternate address. Status bits: 7 busy, 6 ready, 5 write fault, 4 seek complete, 3 data request, 0 error. Error bit 2 is abort.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After reset the error register reads 0x01, status reads 0x00, sector count and sector number read 0x01, the multiple count is 1 and the interrupt is low.
- R2: Writes to addresses 1 to 4 update the shadows of both slots. Reads of those addresses return the shadow of the slot selected by drive/head bit 4.
- R3: A write to drive/head stores the written value OR 0xA0, and it reads back as that value while the selected slot is present.
- R4: While the selected slot is absent, address 5 reads 0xA0 and addresses 0 to 7 otherwise read 0x00. Writing drive/head so that it selects an absent slot sets error bit 2 and status bit 0, and both stay set once a present slot is selected again.
- R5: Address 8 always reads 0xFF, whatever the selected slot's state.
- R6: Command 0xEC on a present disk slot, or 0xA1 on a present packet slot, sets status 0x58 and error 0x00 and raises the interrupt.
- R7: 0xEC or 0xA1 on a slot of the wrong kind or an absent slot, and any opcode not listed in R6, R8 or R13, set status 0x41 and error 0x04 and raise the interrupt.
- R8: Command 0xC6 aborts as in R7 when the sector number exceeds MULT_MAX (default 16). Otherwise it stores the sector count as the selected slot's multiple count (0 is stored as 1), sets status bit 6, clears status bit 0 and raises the interrupt.
- R9: A raised interrupt drives irq high only while device-control bit 1 is 0. When it does, bm_int_set pulses for one cycle.
- R10: A read of address 6 clears irq. A read of address 7 leaves it unchanged.
- R11: A device-control write that takes bit 2 from 0 to 1 sets status 0x90, error 0x01 and clears the interrupt-disable bit. A write that leaves bit 2 at 1 does not repeat this.
- R12: A device-control write that takes bit 2 from 1 to 0 clears status bit 7, sets bit 6, and zeroes the head field. Each slot's sector count and number become 0x01, and its cylinder becomes 0x0000 (disk) or 0xEB14 (packet).
- R13: Commands 0xEF, 0x91 and 0x10 clear status bits 7, 5 and 0, set bits 6 and 4, and raise the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_addr is presented |
| drive_present | input | 2 | Per-slot present flag |
| drive_is_packet | input | 2 | Per-slot type: 1 packet device, 0 disk |
| mult_count | output | 8 | Multiple-sector count of the selected slot |
| irq | output | 1 | Interrupt request |
| bm_int_set | output | 1 | One-cycle pulse each time irq is raised |

## Verification
Read data is combinational from registered state, so it is sampled in the same cycle as the read strobe, just before the edge. The effect of a write, and the irq and bm_int_set response to a command, show up one edge after the write strobe. The clear of irq by a status read also shows one edge after the read. The bench drives every access on the falling edge and leaves it for exactly one rising edge. It then samples irq and bm_int_set at the following falling edge, the only point where the one-cycle pulse is visible. Values that persist, such as status after a command, are read back through later bus reads.

// File: rtl/ata_tf_pkg.sv
// Shared constants and types for the ATA task-file controller.
// Assumes a 4-bit register address space and byte-wide registers.
package ata_tf_pkg;

    localparam logic [3:0] TF_ERR      = 4'd0;
    localparam logic [3:0] TF_CNT      = 4'd1;
    localparam logic [3:0] TF_NUM      = 4'd2;
    localparam logic [3:0] TF_CYL_LO   = 4'd3;
    localparam logic [3:0] TF_CYL_HI   = 4'd4;
    localparam logic [3:0] TF_DH       = 4'd5;
    localparam logic [3:0] TF_CMD      = 4'd6;
    localparam logic [3:0] TF_CTL      = 4'd7;
    localparam logic [3:0] TF_ALT_ADDR = 4'd8;

    localparam logic [7:0] ST_BSY  = 8'h80;
    localparam logic [7:0] ST_RDY  = 8'h40;
    localparam logic [7:0] ST_DF   = 8'h20;
    localparam logic [7:0] ST_DSC  = 8'h10;
    localparam logic [7:0] ST_ERR  = 8'h01;

    localparam logic [7:0] ER_ABRT = 8'h04;

    localparam int CTL_SRST_BIT = 2;
    localparam int CTL_NIEN_BIT = 1;
    localparam int DH_SLOT_BIT  = 4;

    localparam logic [7:0] OP_ID_DISK  = 8'hEC;
    localparam logic [7:0] OP_ID_PKT   = 8'hA1;
    localparam logic [7:0] OP_SET_MULT = 8'hC6;
    localparam logic [7:0] OP_SET_FEAT = 8'hEF;
    localparam logic [7:0] OP_INIT_PAR = 8'h91;
    localparam logic [7:0] OP_RECAL    = 8'h10;

    typedef struct packed {
        logic [7:0] cnt;
        logic [7:0] num;
        logic [7:0] cyl_lo;
        logic [7:0] cyl_hi;
    } tf_shadow_t;

endpackage

// File: rtl/ata_tf_shadow.sv
// Per-slot shadow of the addressing registers plus the multiple count.
// Assumes writes and reset completion never occur in the same cycle.
module ata_tf_shadow
    import ata_tf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       srst_done,
    input  logic       is_packet,
    input  logic       mult_we,
    input  logic [7:0] mult_val,
    output tf_shadow_t shadow,
    output logic [7:0] mult
);

    // Shadow register update: power-on, reset completion, host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '{cnt: 8'h01, num: 8'h01, cyl_lo: 8'h00, cyl_hi: 8'h00};
        end else if (srst_done) begin
            shadow.cnt    <= 8'h01;
            shadow.num    <= 8'h01;
            shadow.cyl_lo <= is_packet ? 8'h14 : 8'h00;
            shadow.cyl_hi <= is_packet ? 8'hEB : 8'h00;
        end else if (wr_en) begin
            case (wr_addr)
                TF_CNT:    shadow.cnt    <= wr_data;
                TF_NUM:    shadow.num    <= wr_data;
                TF_CYL_LO: shadow.cyl_lo <= wr_data;
                TF_CYL_HI: shadow.cyl_hi <= wr_data;
                default:   ;
            endcase
        end
    end

    // Multiple-sector count latch.
    always_ff @(posedge clk) begin
        if (!rst_n)       mult <= 8'h01;
        else if (mult_we) mult <= mult_val;
    end

endmodule

// File: rtl/ata_tf_cmd_decode.sv
// Combinational command decoder: maps an opcode and the selected slot's
// state to next status/error values, an interrupt request and a
// multiple-count update. Holds no state.
module ata_tf_cmd_decode
    import ata_tf_pkg::*;
#(
    parameter int MULT_MAX = 16
) (
    input  logic [7:0] opcode,
    input  logic       present,
    input  logic       is_packet,
    input  logic [7:0] sec_cnt,
    input  logic [7:0] sec_num,
    input  logic [7:0] cur_status,
    input  logic [7:0] cur_error,
    output logic [7:0] new_status,
    output logic [7:0] new_error,
    output logic       raise,
    output logic       mult_we,
    output logic [7:0] mult_val
);

    localparam logic [7:0] MULT_LIMIT = 8'(MULT_MAX);

    logic abort;

    // Opcode decode with the abort path as the fall-through.
    always_comb begin
        new_status = cur_status;
        new_error  = cur_error;
        raise      = 1'b0;
        mult_we    = 1'b0;
        mult_val   = (sec_cnt == 8'h00) ? 8'h01 : sec_cnt;
        abort      = 1'b0;
        case (opcode)
            OP_ID_DISK, OP_ID_PKT: begin
                if (present && (is_packet == (opcode == OP_ID_PKT))) begin
                    new_status = 8'h58;
                    new_error  = 8'h00;
                    raise      = 1'b1;
                end else begin
                    abort = 1'b1;
                end
            end
            OP_SET_MULT: begin
                if (sec_num > MULT_LIMIT) begin
                    abort = 1'b1;
                end else begin
                    mult_we    = 1'b1;
                    new_status = (cur_status | ST_RDY) & ~ST_ERR;
                    raise      = 1'b1;
                end
            end
            OP_SET_FEAT, OP_INIT_PAR, OP_RECAL: begin
                new_status = (cur_status & ~(ST_BSY | ST_DF | ST_ERR)) | ST_RDY | ST_DSC;
                raise      = 1'b1;
            end
            default: abort = 1'b1;
        endcase
        if (abort) begin
            new_status = ST_RDY | ST_ERR;
            new_error  = ER_ABRT;
            raise      = 1'b1;
        end
    end

endmodule

// File: rtl/ata_tf_read_mux.sv
// Read-data selection for the task-file address space, including the
// fixed patterns returned while the selected slot is absent.
module ata_tf_read_mux
    import ata_tf_pkg::*;
(
    input  logic [3:0] addr,
    input  logic       sel_present,
    input  tf_shadow_t sel_shadow,
    input  logic [7:0] error_q,
    input  logic [7:0] status_q,
    input  logic [7:0] dh_q,
    output logic [7:0] rdata
);

    // Address decode of readable registers.
    always_comb begin
        rdata = 8'h00;
        if (addr == TF_ALT_ADDR) begin
            rdata = 8'hFF;
        end else if (!sel_present) begin
            rdata = (addr == TF_DH) ? 8'hA0 : 8'h00;
        end else begin
            case (addr)
                TF_ERR:         rdata = error_q;
                TF_CNT:         rdata = sel_shadow.cnt;
                TF_NUM:         rdata = sel_shadow.num;
                TF_CYL_LO:      rdata = sel_shadow.cyl_lo;
                TF_CYL_HI:      rdata = sel_shadow.cyl_hi;
                TF_DH:          rdata = dh_q;
                TF_CMD, TF_CTL: rdata = status_q;
                default:        rdata = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/ata_taskfile_ctrl.sv
// Task-file register controller for one ATA channel with two slots.
// Holds the channel-wide registers, sequences soft reset on the edges of
// the device-control reset bit, applies decoded commands and drives a
// maskable interrupt. Assumes bus_wr and bus_rd are never high together.
module ata_taskfile_ctrl
    import ata_tf_pkg::*;
#(
    parameter int MULT_MAX = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [1:0] drive_present,
    input  logic [1:0] drive_is_packet,
    output logic [7:0] mult_count,
    output logic       irq,
    output logic       bm_int_set
);

    localparam int NUM_SLOTS = 2;

    logic [7:0] error_q, status_q, ctl_q, dh_q;
    logic       irq_q, bm_q;

    tf_shadow_t shadow   [NUM_SLOTS];
    logic [7:0] mult     [NUM_SLOTS];

    logic       sel;
    logic       ctl_wr, srst_rise, srst_fall, cmd_wr, dh_wr;
    logic [7:0] dec_status, dec_error, dec_mult_val;
    logic       dec_raise, dec_mult_we;

    assign sel       = dh_q[DH_SLOT_BIT];
    assign ctl_wr    = bus_wr && (bus_addr == TF_CTL);
    assign cmd_wr    = bus_wr && (bus_addr == TF_CMD);
    assign dh_wr     = bus_wr && (bus_addr == TF_DH);
    assign srst_rise = ctl_wr && bus_wdata[CTL_SRST_BIT] && !ctl_q[CTL_SRST_BIT];
    assign srst_fall = ctl_wr && !bus_wdata[CTL_SRST_BIT] && ctl_q[CTL_SRST_BIT];

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            ata_tf_shadow u_shadow (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_en     (bus_wr),
                .wr_addr   (bus_addr),
                .wr_data   (bus_wdata),
                .srst_done (srst_fall),
                .is_packet (drive_is_packet[s]),
                .mult_we   (cmd_wr && dec_mult_we && (sel == 1'(s))),
                .mult_val  (dec_mult_val),
                .shadow    (shadow[s]),
                .mult      (mult[s])
            );
        end
    endgenerate

    ata_tf_cmd_decode #(.MULT_MAX(MULT_MAX)) u_decode (
        .opcode     (bus_wdata),
        .present    (drive_present[sel]),
        .is_packet  (drive_is_packet[sel]),
        .sec_cnt    (shadow[sel].cnt),
        .sec_num    (shadow[sel].num),
        .cur_status (status_q),
        .cur_error  (error_q),
        .new_status (dec_status),
        .new_error  (dec_error),
        .raise      (dec_raise),
        .mult_we    (dec_mult_we),
        .mult_val   (dec_mult_val)
    );

    ata_tf_read_mux u_rmux (
        .addr        (bus_addr),
        .sel_present (drive_present[sel]),
        .sel_shadow  (shadow[sel]),
        .error_q     (error_q),
        .status_q    (status_q),
        .dh_q        (dh_q),
        .rdata       (bus_rdata)
    );

    // Channel register state: reset sequencing, selection, command effects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            error_q  <= 8'h01;
            status_q <= 8'h00;
            ctl_q    <= 8'h08;
            dh_q     <= 8'h00;
        end else if (srst_rise) begin
            status_q <= ST_BSY | ST_DSC;
            error_q  <= 8'h01;
            ctl_q    <= bus_wdata & ~(8'h01 << CTL_NIEN_BIT);
        end else if (srst_fall) begin
            status_q  <= (status_q & ~ST_BSY) | ST_RDY;
            dh_q[3:0] <= 4'h0;
            ctl_q     <= bus_wdata;
        end else if (ctl_wr) begin
            ctl_q <= bus_wdata;
        end else if (dh_wr) begin
            dh_q <= bus_wdata | 8'hA0;
            if (!drive_present[bus_wdata[DH_SLOT_BIT]]) begin
                error_q  <= error_q | ER_ABRT;
                status_q <= status_q | ST_ERR;
            end
        end else if (cmd_wr) begin
            status_q <= dec_status;
            error_q  <= dec_error;
        end
    end

    // Interrupt pending flag and bus-master interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            bm_q  <= 1'b0;
        end else begin
            bm_q <= 1'b0;
            if (srst_rise) begin
                irq_q <= 1'b0;
            end else if (cmd_wr && dec_raise && !ctl_q[CTL_NIEN_BIT]) begin
                irq_q <= 1'b1;
                bm_q  <= 1'b1;
            end else if (bus_rd && (bus_addr == TF_CMD)) begin
                irq_q <= 1'b0;
            end
        end
    end

    assign irq        = irq_q;
    assign bm_int_set = bm_q;
    assign mult_count = mult[sel];

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> !ctl_q[CTL_NIEN_BIT]);

    assert_bm_pulse_with_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bm_q |-> irq_q);

    assert_dh_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == TF_DH)) |=> (dh_q[7] && dh_q[5]));

    assert_status_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && (bus_addr == TF_CMD)) |=> !irq);

    assert_srst_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == TF_CTL) && bus_wdata[CTL_SRST_BIT] && !ctl_q[CTL_SRST_BIT])
        |=> (status_q == 8'h90 && error_q == 8'h01 && !irq_q));

    assert_srst_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == TF_CTL) && !bus_wdata[CTL_SRST_BIT] && ctl_q[CTL_SRST_BIT])
        |=> (!status_q[7] && status_q[6] && dh_q[3:0] == 4'h0));

endmodule

// File: tb/ata_taskfile_ctrl_tb_top.sv
`timescale 1ns/1ps
module ata_taskfile_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [1:0] drive_present = 2'b11;
    logic [1:0] drive_is_packet = 2'b10;
    logic [7:0] mult_count;
    logic       irq, bm_int_set;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    ata_taskfile_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .drive_present(drive_present), .drive_is_packet(drive_is_packet),
        .mult_count(mult_count), .irq(irq), .bm_int_set(bm_int_set)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(req, $sformatf("read addr %0d", a), v, exp);
    endtask

    task automatic test_reset_values;
        rd_chk("R1", 4'd0, 8'h01);
        rd_chk("R1", 4'd6, 8'h00);
        rd_chk("R1", 4'd1, 8'h01);
        rd_chk("R1", 4'd2, 8'h01);
        check("R1", "irq", 8'(irq), 8'h00);
        check("R1", "mult_count", mult_count, 8'h01);
        rd_chk("R5", 4'd8, 8'hFF);
    endtask

    task automatic test_shadow_and_select;
        wr(4'd1, 8'h22); wr(4'd2, 8'h33); wr(4'd3, 8'h44); wr(4'd4, 8'h55);
        wr(4'd5, 8'h10);
        rd_chk("R3", 4'd5, 8'hB0);
        rd_chk("R2", 4'd1, 8'h22);
        rd_chk("R2", 4'd4, 8'h55);
        wr(4'd5, 8'h03);
        rd_chk("R3", 4'd5, 8'hA3);
        rd_chk("R2", 4'd3, 8'h44);
    endtask

    task automatic test_identify;
        wr(4'd5, 8'h00);
        wr(4'd6, 8'hEC);
        check("R6", "irq", 8'(irq), 8'h01);
        check("R9", "bm_int_set", 8'(bm_int_set), 8'h01);
        rd_chk("R6", 4'd7, 8'h58);
        check("R10", "irq after alt read", 8'(irq), 8'h01);
        rd_chk("R6", 4'd0, 8'h00);
        rd_chk("R6", 4'd6, 8'h58);
        check("R10", "irq after status read", 8'(irq), 8'h00);
        wr(4'd5, 8'h10);
        wr(4'd6, 8'hA1);
        check("R6", "irq packet id", 8'(irq), 8'h01);
        rd_chk("R6", 4'd6, 8'h58);
    endtask

    task automatic test_abort;
        wr(4'd6, 8'hEC);
        check("R7", "irq wrong type", 8'(irq), 8'h01);
        rd_chk("R7", 4'd0, 8'h04);
        rd_chk("R7", 4'd6, 8'h41);
        wr(4'd5, 8'h00);
        wr(4'd6, 8'h55);
        check("R7", "irq unsupported", 8'(irq), 8'h01);
        rd_chk("R7", 4'd6, 8'h41);
    endtask

    task automatic test_misc_cmd;
        wr(4'd6, 8'hEF);
        check("R13", "irq", 8'(irq), 8'h01);
        rd_chk("R13", 4'd6, 8'h50);
    endtask

    task automatic test_set_multiple;
        wr(4'd1, 8'h00); wr(4'd2, 8'h05);
        wr(4'd6, 8'hC6);
        check("R8", "mult zero count", mult_count, 8'h01);
        check("R8", "irq", 8'(irq), 8'h01);
        rd_chk("R8", 4'd6, 8'h50);
        wr(4'd1, 8'h08); wr(4'd2, 8'h10);
        wr(4'd6, 8'hC6);
        check("R8", "mult at limit", mult_count, 8'h08);
        rd_chk("R8", 4'd6, 8'h50);
        wr(4'd1, 8'h04); wr(4'd2, 8'h11);
        wr(4'd6, 8'hC6);
        check("R8", "mult kept on abort", mult_count, 8'h08);
        rd_chk("R8", 4'd6, 8'h41);
        wr(4'd2, 8'h02);
        wr(4'd6, 8'hC6);
        check("R8", "mult updated", mult_count, 8'h04);
        rd_chk("R8", 4'd6, 8'h40);
    endtask

    task automatic test_irq_mask;
        wr(4'd7, 8'h02);
        wr(4'd6, 8'hEC);
        check("R9", "irq masked", 8'(irq), 8'h00);
        check("R9", "bm masked", 8'(bm_int_set), 8'h00);
        rd_chk("R6", 4'd6, 8'h58);
        wr(4'd7, 8'h00);
    endtask

    task automatic test_soft_reset;
        wr(4'd6, 8'hEC);
        check("R6", "irq before reset", 8'(irq), 8'h01);
        wr(4'd1, 8'h77);
        wr(4'd5, 8'h1F);
        wr(4'd7, 8'h04);
        check("R11", "irq cleared", 8'(irq), 8'h00);
        rd_chk("R11", 4'd7, 8'h90);
        rd_chk("R11", 4'd0, 8'h01);
        wr(4'd6, 8'hEF);
        rd_chk("R13", 4'd7, 8'h50);
        wr(4'd7, 8'h06);
        rd_chk("R11", 4'd7, 8'h50);
        wr(4'd7, 8'h00);
        rd_chk("R12", 4'd7, 8'h50);
        rd_chk("R12", 4'd5, 8'hB0);
        rd_chk("R12", 4'd3, 8'h14);
        rd_chk("R12", 4'd4, 8'hEB);
        rd_chk("R12", 4'd1, 8'h01);
        rd_chk("R12", 4'd2, 8'h01);
        wr(4'd5, 8'h00);
        rd_chk("R12", 4'd3, 8'h00);
        rd_chk("R12", 4'd4, 8'h00);
    endtask

    task automatic test_soft_reset_twice;
        wr(4'd7, 8'h04);
        rd_chk("R11", 4'd7, 8'h90);
        wr(4'd7, 8'h00);
        rd_chk("R12", 4'd7, 8'h50);
    endtask

    task automatic test_absent_slot;
        @(negedge clk);
        drive_present = 2'b01;
        wr(4'd1, 8'h09);
        wr(4'd5, 8'h10);
        rd_chk("R4", 4'd5, 8'hA0);
        rd_chk("R4", 4'd1, 8'h00);
        rd_chk("R4", 4'd6, 8'h00);
        rd_chk("R5", 4'd8, 8'hFF);
        wr(4'd5, 8'h00);
        rd_chk("R4", 4'd0, 8'h05);
        rd_chk("R4", 4'd6, 8'h51);
        rd_chk("R2", 4'd1, 8'h09);
        wr(4'd6, 8'hEC);
        rd_chk("R6", 4'd6, 8'h58);
        wr(4'd5, 8'h10);
        wr(4'd6, 8'hA1);
        wr(4'd5, 8'h00);
        rd_chk("R7", 4'd6, 8'h41);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset_values();
        test_shadow_and_select();
        test_identify();
        test_abort();
        test_misc_cmd();
        test_set_multiple();
        test_irq_mask();
        test_soft_reset();
        test_soft_reset_twice();
        test_absent_slot();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule